// File: doc/BRIEF.md
# Operand Specifier Byte Decoder

This block sits behind the opcode stage of a decoder for a variable-length, little-endian instruction encoding. It takes the operand-specifier bytes of one instruction, one byte per accepted cycle. The first byte is always a mode byte. It may be followed by a scale/index/base byte and then by a 1-byte or 4-byte displacement. From these bytes the block reports the register operand, says whether the second operand is a register or memory, and for memory operands returns the full effective address.

The address is built from two combinational register-file read ports, one for the base register and one for the index register. The index is shifted by the scale, and the sign-extended or little-endian displacement is added. A separate size input, captured with the mode byte, selects between the word-register and byte-register views of the register numbers. The block accepts bytes on a valid/ready handshake and raises a one-cycle result strobe in the cycle after the last byte is consumed. The next mode byte may be accepted in that same strobe cycle.

Top module: `opnd_spec_decoder`

## Requirements
- R1: The mode byte is split as bits 7:6 = addressing class, bits 5:3 = register operand number, bits 2:0 = second-operand selector. The register operand number is reported on every result.
- R2: Class 11 makes the second operand a register named by bits 2:0. That instruction is one byte long. The result reports `resRmIsReg`=1 and `resAddr`=0. For memory results, `resRmReg` and `resRmHi` are 0.
- R3: `byteSz` is sampled only with the mode byte. When it is 0 (word view), a number n maps to physical register n with high flag 0. When it is 1 (byte view), n maps to physical register {0,n[1:0]} with high flag n[2]. This mapping applies to the register operand, and to the second operand when that operand is a register.
- R4: Class 00 with selector other than 100 gives address = register[selector]. That instruction is one byte long.
- R5: Class 01 adds one displacement byte, sign-extended to 32 bits.
- R6: Class 10 adds a 4-byte displacement, received least significant byte first.
- R7: In classes 00, 01 and 10, selector 100 means a scale/index/base byte follows. Its bits 7:6 are the scale s, bits 5:3 the index, and bits 2:0 the base. The address is base + (index << s) + displacement. The displacement is absent for class 00.
- R8: An index field of 100 in the scale/index/base byte means no index term is added.
- R9: `resValid` is high for exactly one cycle, in the cycle after the last byte of an instruction is accepted. At all other times the result outputs hold their previous values.
- R10: `byteReady` is low during reset and high from the second cycle after reset is released. A mode byte may be accepted in the same cycle as the previous instruction's strobe, so one-byte instructions can be decoded every cycle.
- R11: Cycles with `byteValid` low do not advance the parse and do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Input byte present |
| byteData | input | 8 | Operand-specifier byte |
| byteSz | input | 1 | 1 = byte-register view; sampled with the mode byte |
| byteReady | output | 1 | Block can take a byte |
| rfBaseSel | output | 3 | Base register read select |
| rfBaseData | input | 32 | Base register read data (combinational) |
| rfIdxSel | output | 3 | Index register read select |
| rfIdxData | input | 32 | Index register read data (combinational) |
| resValid | output | 1 | One-cycle result strobe |
| resRegOp | output | 3 | Physical register of the register operand |
| resRegOpHi | output | 1 | Register operand is the high byte lane |
| resRmIsReg | output | 1 | Second operand is a register |
| resRmReg | output | 3 | Physical register of the second operand (0 for memory) |
| resRmHi | output | 1 | Second operand is the high byte lane |
| resByteSz | output | 1 | Size view used for this result |
| resAddr | output | 32 | Effective address (0 for register operands) |

## Verification
Two things can happen in the same cycle: the result strobe of one instruction and the acceptance of the next instruction's mode byte. They coincide whenever bytes arrive without gaps.

The bench provokes this by sending runs of one-byte register-form instructions back to back, and by sending random mixed-length instructions with bubbles disabled. In each strobe cycle it compares the outputs against values computed from the bytes it sent. It also confirms that the strobe never appears before an instruction's last byte, so an accept in a strobe cycle must neither disturb the result just produced nor be lost from the next parse.

// File: rtl/opnd_spec_pkg.sv
package opnd_spec_pkg;

  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_DISP8  = 2'b01;
  localparam logic [1:0] MOD_DISPW  = 2'b10;
  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [2:0] RM_SIB     = 3'b100;
  localparam logic [2:0] IDX_NONE   = 3'b100;

  typedef enum logic [1:0] {
    ST_MODE = 2'd0,
    ST_SIB  = 2'd1,
    ST_DISP = 2'd2
  } parse_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldMode;
    logic ldSib;
    logic ldDisp;
    logic finish;
    logic useCurMode;
    logic useCurSib;
  } opnd_ctl_t;

  // returns {highLane, physicalRegister}
  function automatic logic [3:0] mapRegNum(input logic [2:0] num, input logic byteView);
    mapRegNum = byteView ? {num[2], 1'b0, num[1:0]} : {1'b0, num};
  endfunction

endpackage

// File: rtl/opnd_spec_ctrl.sv
module opnd_spec_ctrl
  import opnd_spec_pkg::*;
#(
  parameter int DISP_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [1:0] curMod,
  input  logic [2:0] curRm,
  input  logic [1:0] heldMod,
  output logic       byteReady,
  output opnd_ctl_t  ctl
);

  localparam int CNT_W = $clog2(DISP_BYTES + 1);

  parse_state_e state, stateNext;
  logic [CNT_W-1:0] dispLeft, leftNext;
  logic readyQ;
  logic accept;

  function automatic logic [CNT_W-1:0] dispLen(input logic [1:0] m);
    dispLen = (m == MOD_DISP8) ? CNT_W'(1) : CNT_W'(DISP_BYTES);
  endfunction

  assign byteReady = readyQ;
  assign accept    = byteValid && readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_MODE;
      dispLeft <= '0;
      readyQ   <= 1'b0;
    end else begin
      state    <= stateNext;
      dispLeft <= leftNext;
      readyQ   <= 1'b1;
    end
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    leftNext  = dispLeft;
    unique case (state)
      ST_MODE: begin
        ctl.useCurMode = 1'b1;
        if (accept) begin
          ctl.ldMode = 1'b1;
          if (curMod == MOD_REG) begin
            ctl.finish = 1'b1;
          end else if (curRm == RM_SIB) begin
            stateNext = ST_SIB;
          end else if (curMod == MOD_NODISP) begin
            ctl.finish = 1'b1;
          end else begin
            stateNext = ST_DISP;
            leftNext  = dispLen(curMod);
          end
        end
      end
      ST_SIB: begin
        ctl.useCurSib = 1'b1;
        if (accept) begin
          ctl.ldSib = 1'b1;
          if (heldMod == MOD_NODISP) begin
            ctl.finish = 1'b1;
            stateNext  = ST_MODE;
          end else begin
            stateNext = ST_DISP;
            leftNext  = dispLen(heldMod);
          end
        end
      end
      ST_DISP: begin
        if (accept) begin
          ctl.ldDisp = 1'b1;
          if (dispLeft == CNT_W'(1)) begin
            ctl.finish = 1'b1;
            stateNext  = ST_MODE;
          end else begin
            leftNext = dispLeft - CNT_W'(1);
          end
        end
      end
      default: stateNext = ST_MODE;
    endcase
  end

endmodule

// File: rtl/opnd_spec_agen.sv
module opnd_spec_agen #(
  parameter int ADDR_W = 32
) (
  input  logic              isReg,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic              idxEn,
  input  logic [1:0]        scale,
  input  logic [ADDR_W-1:0] dispVal,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] idxTerm;

  assign idxTerm = idxEn ? (idxVal << scale) : '0;
  assign addr    = isReg ? '0 : (baseVal + idxTerm + dispVal);

endmodule

// File: rtl/opnd_spec_dp.sv
module opnd_spec_dp
  import opnd_spec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  opnd_ctl_t         ctl,
  input  logic [7:0]        byteData,
  input  logic              byteSz,
  output logic [1:0]        heldMod,
  output logic [2:0]        rfBaseSel,
  input  logic [ADDR_W-1:0] rfBaseData,
  output logic [2:0]        rfIdxSel,
  input  logic [ADDR_W-1:0] rfIdxData,
  output logic              resValid,
  output logic [2:0]        resRegOp,
  output logic              resRegOpHi,
  output logic              resRmIsReg,
  output logic [2:0]        resRmReg,
  output logic              resRmHi,
  output logic              resByteSz,
  output logic [ADDR_W-1:0] resAddr
);

  localparam int HELD_W = ADDR_W - 8;

  logic [7:0]        modeQ, sibQ;
  logic              szQ;
  logic [HELD_W-1:0] dispQ;

  logic [7:0]        effMode, effSib;
  logic              effSz;
  logic              isReg, hasSib, idxEn;
  logic [ADDR_W-1:0] dispNext, dispVal, addrNext;
  logic [3:0]        regMap, rmMap;

  assign effMode  = ctl.useCurMode ? byteData : modeQ;
  assign effSib   = ctl.useCurSib ? byteData : sibQ;
  assign effSz    = ctl.useCurMode ? byteSz : szQ;
  assign heldMod  = modeQ[7:6];

  assign isReg    = (effMode[7:6] == MOD_REG);
  assign hasSib   = !isReg && (effMode[2:0] == RM_SIB);
  assign idxEn    = hasSib && (effSib[5:3] != IDX_NONE);

  assign rfBaseSel = hasSib ? effSib[2:0] : effMode[2:0];
  assign rfIdxSel  = effSib[5:3];

  // little-endian assembly: each new byte enters at the top
  assign dispNext = {byteData, dispQ};

  always_comb begin
    unique case (effMode[7:6])
      MOD_DISP8: dispVal = {{(ADDR_W-8){byteData[7]}}, byteData};
      MOD_DISPW: dispVal = dispNext;
      default:   dispVal = '0;
    endcase
  end

  opnd_spec_agen #(.ADDR_W(ADDR_W)) u_agen (
    .isReg  (isReg),
    .baseVal(rfBaseData),
    .idxVal (rfIdxData),
    .idxEn  (idxEn),
    .scale  (effSib[7:6]),
    .dispVal(dispVal),
    .addr   (addrNext)
  );

  assign regMap = mapRegNum(effMode[5:3], effSz);
  assign rmMap  = isReg ? mapRegNum(effMode[2:0], effSz) : 4'd0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      sibQ  <= '0;
      szQ   <= 1'b0;
      dispQ <= '0;
    end else begin
      if (ctl.ldMode) begin
        modeQ <= byteData;
        szQ   <= byteSz;
        dispQ <= '0;
      end
      if (ctl.ldSib)  sibQ  <= byteData;
      if (ctl.ldDisp) dispQ <= dispNext[ADDR_W-1:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resRegOp   <= '0;
      resRegOpHi <= 1'b0;
      resRmIsReg <= 1'b0;
      resRmReg   <= '0;
      resRmHi    <= 1'b0;
      resByteSz  <= 1'b0;
      resAddr    <= '0;
    end else begin
      resValid <= ctl.finish;
      if (ctl.finish) begin
        resRegOp   <= regMap[2:0];
        resRegOpHi <= regMap[3];
        resRmIsReg <= isReg;
        resRmReg   <= rmMap[2:0];
        resRmHi    <= rmMap[3];
        resByteSz  <= effSz;
        resAddr    <= addrNext;
      end
    end
  end

endmodule

// File: rtl/opnd_spec_decoder.sv
module opnd_spec_decoder
  import opnd_spec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              byteSz,
  output logic              byteReady,
  output logic [2:0]        rfBaseSel,
  input  logic [ADDR_W-1:0] rfBaseData,
  output logic [2:0]        rfIdxSel,
  input  logic [ADDR_W-1:0] rfIdxData,
  output logic              resValid,
  output logic [2:0]        resRegOp,
  output logic              resRegOpHi,
  output logic              resRmIsReg,
  output logic [2:0]        resRmReg,
  output logic              resRmHi,
  output logic              resByteSz,
  output logic [ADDR_W-1:0] resAddr
);

  localparam int DISP_BYTES = ADDR_W / 8;

  opnd_ctl_t  ctl;
  logic [1:0] heldMod;

  opnd_spec_ctrl #(.DISP_BYTES(DISP_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .curMod   (byteData[7:6]),
    .curRm    (byteData[2:0]),
    .heldMod  (heldMod),
    .byteReady(byteReady),
    .ctl      (ctl)
  );

  opnd_spec_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .byteData  (byteData),
    .byteSz    (byteSz),
    .heldMod   (heldMod),
    .rfBaseSel (rfBaseSel),
    .rfBaseData(rfBaseData),
    .rfIdxSel  (rfIdxSel),
    .rfIdxData (rfIdxData),
    .resValid  (resValid),
    .resRegOp  (resRegOp),
    .resRegOpHi(resRegOpHi),
    .resRmIsReg(resRmIsReg),
    .resRmReg  (resRmReg),
    .resRmHi   (resRmHi),
    .resByteSz (resByteSz),
    .resAddr   (resAddr)
  );

endmodule

// File: rtl/opnd_spec_decoder_chk.sv
module opnd_spec_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              byteReady,
  input logic              resValid,
  input logic [2:0]        resRegOp,
  input logic              resRegOpHi,
  input logic              resRmIsReg,
  input logic [2:0]        resRmReg,
  input logic              resRmHi,
  input logic              resByteSz,
  input logic [ADDR_W-1:0] resAddr
);

  // R9: a strobe is always preceded by an accepted byte
  p_strobe_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(byteValid && byteReady));

  // R9, R11: results move only in strobe cycles
  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resAddr) && $stable(resRegOp) && $stable(resRmIsReg)
                   && $stable(resRmReg) && $stable(resRegOpHi) && $stable(resRmHi)));

  // R3: the word view never reports a high byte lane
  p_word_no_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resByteSz) |-> (!resRegOpHi && !resRmHi));

  // R3: the byte view only names physical registers 0..3
  p_byte_low_regs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resByteSz) |-> (resRegOp[2] == 1'b0 && resRmReg[2] == 1'b0));

  // R2: register operands carry a zero address
  p_reg_addr_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resRmIsReg) |-> (resAddr == '0));

  // R2: memory operands carry no second register
  p_mem_no_rm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resRmIsReg) |-> (resRmReg == 3'd0 && !resRmHi));

  // R10: ready stays up once out of reset
  p_ready_up_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> byteReady);

endmodule

bind opnd_spec_decoder opnd_spec_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteValid (byteValid),
  .byteReady (byteReady),
  .resValid  (resValid),
  .resRegOp  (resRegOp),
  .resRegOpHi(resRegOpHi),
  .resRmIsReg(resRmIsReg),
  .resRmReg  (resRmReg),
  .resRmHi   (resRmHi),
  .resByteSz (resByteSz),
  .resAddr   (resAddr)
);

// File: tb/opnd_spec_decoder_bench.sv
module opnd_spec_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteSz = 1'b0;
  logic        byteReady;
  logic [2:0]  rfBaseSel, rfIdxSel;
  logic [31:0] rfBaseData, rfIdxData;
  logic        resValid, resRegOpHi, resRmIsReg, resRmHi, resByteSz;
  logic [2:0]  resRegOp, resRmReg;
  logic [31:0] resAddr;

  logic [31:0] rf [0:7];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  assign rfBaseData = rf[rfBaseSel];
  assign rfIdxData  = rf[rfIdxSel];

  opnd_spec_decoder u_opnd_spec_decoder (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteSz(byteSz), .byteReady(byteReady),
    .rfBaseSel(rfBaseSel), .rfBaseData(rfBaseData),
    .rfIdxSel(rfIdxSel), .rfIdxData(rfIdxData),
    .resValid(resValid), .resRegOp(resRegOp), .resRegOpHi(resRegOpHi),
    .resRmIsReg(resRmIsReg), .resRmReg(resRmReg), .resRmHi(resRmHi),
    .resByteSz(resByteSz), .resAddr(resAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expMap(input logic [2:0] n, input bit b);
    return b ? {n[2], 1'b0, n[1:0]} : {1'b0, n};
  endfunction

  function automatic logic [31:0] expAddr(input logic [7:0] mb, input logic [7:0] sb, input logic [31:0] disp);
    logic [31:0] a;
    if (mb[7:6] == 2'b11) return 32'h0;
    if (mb[2:0] == 3'b100) begin
      a = rf[sb[2:0]];
      if (sb[5:3] != 3'b100) a = a + (rf[sb[5:3]] << sb[7:6]);
    end else a = rf[mb[2:0]];
    if (mb[7:6] == 2'b01) a = a + {{24{disp[7]}}, disp[7:0]};
    if (mb[7:6] == 2'b10) a = a + disp;
    return a;
  endfunction

  function automatic string addrTag(input logic [7:0] mb, input logic [7:0] sb);
    if (mb[7:6] == 2'b11) return "R2 reg-form address";
    if (mb[2:0] == 3'b100) return (sb[5:3] == 3'b100) ? "R8 no-index address" : "R7 scaled-index address";
    if (mb[7:6] == 2'b00) return "R4 register-indirect address";
    if (mb[7:6] == 2'b01) return "R5 short displacement address";
    return "R6 long displacement address";
  endfunction

  task automatic sendInstr(input logic [7:0] mb, input logic [7:0] sb, input logic [31:0] disp,
                           input bit bsz, input int bubblePct);
    logic [7:0] bytes [0:5];
    int n = 1;
    logic [3:0] eReg, eRm;
    logic [31:0] eAddr;
    logic [31:0] heldAddr;
    bit earlyOk = 1;
    bytes[0] = mb;
    if (mb[7:6] != 2'b11) begin
      if (mb[2:0] == 3'b100) begin bytes[n] = sb; n++; end
      if (mb[7:6] == 2'b01) begin bytes[n] = disp[7:0]; n++; end
      if (mb[7:6] == 2'b10) begin
        for (int k = 0; k < 4; k++) begin bytes[n] = disp[8*k +: 8]; n++; end
      end
    end
    eAddr = expAddr(mb, sb, disp);
    eReg  = expMap(mb[5:3], bsz);
    eRm   = (mb[7:6] == 2'b11) ? expMap(mb[2:0], bsz) : 4'd0;
    for (int i = 0; i < n; i++) begin
      if (int'($urandom_range(99)) < bubblePct) begin
        heldAddr  = resAddr;
        byteValid = 1'b0;
        byteData  = 8'($urandom);
        byteSz    = 1'($urandom);
        @(negedge clk);
        check(!resValid && resAddr == heldAddr, "R11 bubble leaves result", resAddr, heldAddr);
      end
      byteValid = 1'b1;
      byteData  = bytes[i];
      byteSz    = (i == 0) ? bsz : 1'($urandom);
      @(negedge clk);
      if (i < n - 1 && resValid) earlyOk = 0;
    end
    byteValid = 1'b0;
    check(earlyOk, "R9 no strobe before last byte", 32'(earlyOk), 32'd1);
    check(resValid === 1'b1, "R9 strobe after last byte", 32'(resValid), 32'd1);
    check(byteReady === 1'b1, "R10 ready in strobe cycle", 32'(byteReady), 32'd1);
    check({resRegOpHi, resRegOp} == eReg, "R1 R3 register operand", 32'({resRegOpHi, resRegOp}), 32'(eReg));
    check(resRmIsReg == (mb[7:6] == 2'b11), "R2 operand kind", 32'(resRmIsReg), 32'(mb[7:6] == 2'b11));
    check({resRmHi, resRmReg} == eRm, "R2 R3 second register", 32'({resRmHi, resRmReg}), 32'(eRm));
    check(resByteSz == bsz, "R3 sampled size", 32'(resByteSz), 32'(bsz));
    check(resAddr == eAddr, addrTag(mb, sb), resAddr, eAddr);
  endtask

  initial begin
    void'($urandom(32'h1C0DE));
    for (int r = 0; r < 8; r++) rf[r] = $urandom;
    rf[1] = 32'h0000_1000;
    rf[6] = 32'h0000_0040;
    repeat (3) @(negedge clk);
    // reset state
    check(byteReady === 1'b0, "R10 ready low in reset", 32'(byteReady), 32'd0);
    check(resValid === 1'b0 && resAddr == 0, "R9 idle result in reset", resAddr, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(byteReady === 1'b1, "R10 ready after reset", 32'(byteReady), 32'd1);

    // directed corners
    sendInstr(8'b11_010_011, 8'h00, 32'h0, 1'b0, 0);     // R2 word regs
    sendInstr(8'b11_110_101, 8'h00, 32'h0, 1'b1, 0);     // R3 byte regs, high lanes
    sendInstr(8'b11_100_100, 8'h00, 32'h0, 1'b0, 0);     // R2 selector 100 still a register
    sendInstr(8'b00_001_001, 8'h00, 32'h0, 1'b0, 0);     // R4
    sendInstr(8'b01_000_001, 8'h00, 32'h80, 1'b0, 0);    // R5 negative byte
    sendInstr(8'b01_000_110, 8'h00, 32'h7F, 1'b1, 0);    // R5 positive byte
    sendInstr(8'b10_011_001, 8'h00, 32'hDEADBEEF, 1'b0, 0); // R6
    sendInstr(8'b00_000_100, 8'b11_110_001, 32'h0, 1'b0, 0); // R7 scale 8
    sendInstr(8'b01_000_100, 8'b10_100_110, 32'hF0, 1'b0, 0); // R8 no index
    sendInstr(8'b10_101_100, 8'b01_001_110, 32'h12345678, 1'b1, 100); // R7 R11 bubbles
    // R10: back-to-back one-byte instructions
    for (int k = 0; k < 8; k++) sendInstr({2'b11, 6'($urandom)}, 8'h00, 32'h0, 1'($urandom), 0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      if (k % 50 == 0) for (int r = 0; r < 8; r++) rf[r] = $urandom;
      sendInstr(8'($urandom), 8'($urandom), $urandom, 1'($urandom), (k % 3 == 0) ? 0 : 30);
    end
    @(negedge clk);
    check(resValid === 1'b0, "R9 strobe lasts one cycle", 32'(resValid), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule